// File: doc/BRIEF.md
# SDRAM Bank Command Timing Guard

This block sits on the command path between an SDRAM controller's sequencer and the memory's command pins. It watches every command that is issued and keeps, for each bank and for the device as a whole, the minimum spacing that must pass before each kind of command may follow. For the opcode and bank currently presented it returns a vector of ready bits, one per opcode. If a command is issued while its ready bit is low, a sticky violation flag is raised and the rejected command is left out of the timing state. A separate flag warns when any bank has kept a row open for its maximum allowed time.

All bank timings are given as nanosecond parameters. At elaboration they are turned into clock counts from a clock-period parameter. The write-recovery spacings are given directly in clocks. Each bank runs a two-state machine. Its states are `BANK_IDLE` and `BANK_OPEN`. The transition *open* (IDLE to OPEN) is taken on an accepted ACTIVE, and the transition *close* (OPEN to IDLE) is taken on an accepted PRECHARGE. A global machine has the states `G_NORMAL` and `G_RECOVER`. The transition *enter recovery* (NORMAL to RECOVER) is taken on an accepted AUTO REFRESH or self-refresh exit. The transition *recovered* (RECOVER to NORMAL) is taken when the refresh cycle count runs out.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Every nanosecond limit becomes a clock count equal to ceil(ns / CLK_NS). The same-bank ACTIVE-to-ACTIVE count is the larger of ceil(T_RC_NS / CLK_NS) and the sum of the RAS-minimum and precharge counts. A limit of N clocks means the follow-up command is ready exactly N cycles after the command that started it.
- R2: Opcodes are encoded as NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, BURST STOP=5, AUTO REFRESH=6 and SELF-REFRESH EXIT=7. Bit i of `cmd_ready` refers to opcode i for the bank on `cmd_bank`. After reset all banks are idle and all counters are clear, so `cmd_ready` is 8'hF3, and both `violation` and `row_overdue` are 0.
- R3: READ and WRITE are ready only for an open bank, and only once the RAS-to-CAS count has elapsed since that bank's ACTIVE.
- R4: PRECHARGE of an open bank is ready only once the RAS-minimum count has elapsed since its ACTIVE. PRECHARGE of an idle bank is always ready outside refresh recovery, and it has no effect on the bank.
- R5: ACTIVE is ready only once the active-to-active count has elapsed since the last ACTIVE to any bank.
- R6: ACTIVE is ready only for an idle bank, and only once both the precharge count since that bank's PRECHARGE and the row-cycle count since its previous ACTIVE have elapsed.
- R7: After a WRITE of BURST_LEN beats, the last data-in falls BURST_LEN-1 cycles after the command. From that point, a READ or WRITE to any bank waits CDL_CLK cycles, a BURST STOP waits BDL_CLK cycles, and a PRECHARGE of the written bank waits RDL_CLK cycles. Consecutive READs may issue every cycle.
- R8: After an AUTO REFRESH or self-refresh exit, every opcode except NOP is blocked for the refresh cycle count. AUTO REFRESH is ready only when every bank is idle and its precharge count has elapsed.
- R9: An issued command whose ready bit is low sets `violation`, which stays at 1 until reset. Such a command changes no bank or counter state.
- R10: `row_overdue` is 1 while some bank has been open for at least ceil(T_RAS_MAX_NS / CLK_NS) cycles. It returns to 0 in the cycle after that bank is precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | Opcode being issued or queried |
| cmd_bank | input | BW | Target bank of the opcode |
| cmd_ready | output | 8 | Per-opcode ready bits for `cmd_bank` |
| violation | output | 1 | Sticky flag: a blocked command was issued |
| row_overdue | output | 1 | A row has been open too long |

## Verification
The assertions check on every cycle that idle counters stay at zero, and that an accepted ACTIVE immediately withdraws column and precharge readiness for its bank. They also check that an accepted refresh holds off every command, that the recovery state never outlives its counter, that a precharge clears the overdue warning, and that the violation flag never drops. The exact cycle on which each ready bit rises can only be shown by the bench's sweeps. Each sweep issues one anchor command and then queries a follow-up opcode on every later cycle. The same holds for the row-cycle and precharge interplay, the all-idle condition for refresh, and the rule that a rejected command leaves no trace in the timing state.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_BST = 3'd5,
        OP_REF = 3'd6,
        OP_SRX = 3'd7
    } guard_op_e;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_OPEN = 1'b1
    } bank_state_e;

    typedef enum logic {
        G_NORMAL  = 1'b0,
        G_RECOVER = 1'b1
    } glob_state_e;

    // ns limit to clock count, rounded up
    function automatic int ns_to_clk(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    // count register preload: a limit of n clocks holds n-1 after the issuing edge
    function automatic int clk_to_gap(input int n);
        return (n > 0) ? n - 1 : 0;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_guard_downcnt.sv
module sdram_guard_downcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R1: an expired spacing stays expired until a new command reloads it
    a_r1_saturate_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

endmodule

// File: rtl/sdram_guard_bank.sv
module sdram_guard_bank
    import sdram_guard_pkg::*;
#(
    parameter int CW      = 4,
    parameter int AW      = 8,
    parameter int RCD_GAP = 1,
    parameter int RAS_GAP = 3,
    parameter int RC_GAP  = 5,
    parameter int RP_GAP  = 1,
    parameter int WR_GAP  = 1,
    parameter int RMAX    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_wr,
    input  logic do_pre,
    output logic is_idle,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok,
    output logic rp_done,
    output logic overdue
);

    bank_state_e state, state_nxt;
    logic        rcd_z, ras_z, rc_z, rp_z, wr_z;
    logic        closing;
    logic [AW-1:0] age;

    assign closing = do_pre && (state == BANK_OPEN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= BANK_IDLE;
        else
            state <= state_nxt;
    end

    // transitions: open on ACTIVE, close on PRECHARGE
    always_comb begin
        state_nxt = state;
        unique case (state)
            BANK_IDLE: if (do_act) state_nxt = BANK_OPEN;
            BANK_OPEN: if (do_pre) state_nxt = BANK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_idle = (state == BANK_IDLE);
        act_ok  = (state == BANK_IDLE) && rp_z && rc_z;
        col_ok  = (state == BANK_OPEN) && rcd_z;
        pre_ok  = (state == BANK_OPEN) && ras_z && wr_z;
        rp_done = rp_z;
        overdue = (state == BANK_OPEN) && (age == AW'(RMAX));
    end

    // open-row age, saturating at the overdue limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '0;
        else if (do_act)
            age <= AW'(1);
        else if (state == BANK_IDLE)
            age <= '0;
        else if (age != AW'(RMAX))
            age <= age + 1'b1;
    end

    sdram_guard_downcnt #(.W(CW)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(CW'(RCD_GAP)), .zero(rcd_z));
    sdram_guard_downcnt #(.W(CW)) u_ras (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(CW'(RAS_GAP)), .zero(ras_z));
    sdram_guard_downcnt #(.W(CW)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(CW'(RC_GAP)), .zero(rc_z));
    sdram_guard_downcnt #(.W(CW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(closing), .load_val(CW'(RP_GAP)), .zero(rp_z));
    sdram_guard_downcnt #(.W(CW)) u_wr (
        .clk(clk), .rst_n(rst_n), .load(do_wr), .load_val(CW'(WR_GAP)), .zero(wr_z));

    generate
        if (RCD_GAP > 0) begin : g_rcd_chk
            // R3: a column command cannot follow its ACTIVE on the next cycle
            a_r3_rcd_after_act: assert property (@(posedge clk) disable iff (!rst_n)
                do_act |=> !col_ok);
        end
        if (RAS_GAP > 0) begin : g_ras_chk
            // R4: precharge is withheld right after the row opens
            a_r4_ras_after_act: assert property (@(posedge clk) disable iff (!rst_n)
                do_act |=> !pre_ok);
        end
    endgenerate

    // R10: closing a row removes its overdue warning
    a_r10_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> !overdue);

endmodule

// File: rtl/sdram_guard_global.sv
module sdram_guard_global
    import sdram_guard_pkg::*;
#(
    parameter int CW      = 4,
    parameter int RRD_GAP = 1,
    parameter int COL_GAP = 0,
    parameter int BST_GAP = 0,
    parameter int RFC_GAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_act,
    input  logic acc_wr,
    input  logic acc_refresh,
    output logic rrd_ok,
    output logic col_ok,
    output logic bst_ok,
    output logic g_ok
);

    glob_state_e   state, state_nxt;
    logic [CW-1:0] rfc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rfc_cnt <= '0;
        else if (acc_refresh)
            rfc_cnt <= CW'(RFC_GAP);
        else if (rfc_cnt != '0)
            rfc_cnt <= rfc_cnt - 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= G_NORMAL;
        else
            state <= state_nxt;
    end

    // transitions: enter recovery on refresh, leave when the count runs out
    always_comb begin
        state_nxt = state;
        unique case (state)
            G_NORMAL:  if (acc_refresh && (RFC_GAP != 0)) state_nxt = G_RECOVER;
            G_RECOVER: if (rfc_cnt <= CW'(1))             state_nxt = G_NORMAL;
        endcase
    end

    // outputs
    always_comb begin
        g_ok = (state == G_NORMAL);
    end

    sdram_guard_downcnt #(.W(CW)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(acc_act), .load_val(CW'(RRD_GAP)), .zero(rrd_ok));
    sdram_guard_downcnt #(.W(CW)) u_col (
        .clk(clk), .rst_n(rst_n), .load(acc_wr), .load_val(CW'(COL_GAP)), .zero(col_ok));
    sdram_guard_downcnt #(.W(CW)) u_bst (
        .clk(clk), .rst_n(rst_n), .load(acc_wr), .load_val(CW'(BST_GAP)), .zero(bst_ok));

    // R8: recovery state never outlives its counter
    a_r8_recover_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_RECOVER) |-> (rfc_cnt != '0));

    generate
        if (RFC_GAP > 0) begin : g_rfc_chk
            // R8: an accepted refresh holds off commands on the next cycle
            a_r8_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                acc_refresh |=> !g_ok);
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int CLK_NS       = 10,
    parameter int BURST_LEN    = 1,
    parameter int T_RRD_NS     = 12,
    parameter int T_RCD_NS     = 18,
    parameter int T_RP_NS      = 18,
    parameter int T_RAS_NS     = 40,
    parameter int T_RC_NS      = 60,
    parameter int T_RFC_NS     = 60,
    parameter int T_RAS_MAX_NS = 100000,
    parameter int CDL_CLK      = 1,
    parameter int RDL_CLK      = 2,
    parameter int BDL_CLK      = 1,
    localparam int BW          = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    output logic [7:0]    cmd_ready,
    output logic          violation,
    output logic          row_overdue
);

    localparam int RRD_C  = ns_to_clk(T_RRD_NS, CLK_NS);
    localparam int RCD_C  = ns_to_clk(T_RCD_NS, CLK_NS);
    localparam int RP_C   = ns_to_clk(T_RP_NS, CLK_NS);
    localparam int RAS_C  = ns_to_clk(T_RAS_NS, CLK_NS);
    localparam int RC_C   = max_int(ns_to_clk(T_RC_NS, CLK_NS), RAS_C + RP_C);
    localparam int RFC_C  = ns_to_clk(T_RFC_NS, CLK_NS);
    localparam int RMAX_C = max_int(ns_to_clk(T_RAS_MAX_NS, CLK_NS), 1);
    localparam int COL_C  = BURST_LEN - 1 + CDL_CLK;
    localparam int BST_C  = BURST_LEN - 1 + BDL_CLK;
    localparam int WRP_C  = BURST_LEN - 1 + RDL_CLK;

    localparam int MAX_GAP = max_int(max_int(max_int(RRD_C, RCD_C), max_int(RP_C, RAS_C)),
                                     max_int(max_int(RC_C, RFC_C),
                                             max_int(COL_C, max_int(BST_C, WRP_C))));
    localparam int CW = $clog2(MAX_GAP + 2);
    localparam int AW = $clog2(RMAX_C + 1);

    guard_op_e op;
    logic [7:0] rdy;
    logic       accepted;

    logic [NUM_BANKS-1:0] do_act, do_wr, do_pre;
    logic [NUM_BANKS-1:0] b_idle, b_act_ok, b_col_ok, b_pre_ok, b_rp_done, b_overdue;
    logic rrd_ok, gcol_ok, bst_ok, g_ok;
    logic all_idle, all_rp;

    assign op       = guard_op_e'(cmd_op);
    assign accepted = cmd_valid && rdy[cmd_op];
    assign all_idle = &b_idle;
    assign all_rp   = &b_rp_done;

    generate
        for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
            assign do_act[i] = accepted && (op == OP_ACT) && (cmd_bank == BW'(i));
            assign do_wr[i]  = accepted && (op == OP_WR)  && (cmd_bank == BW'(i));
            assign do_pre[i] = accepted && (op == OP_PRE) && (cmd_bank == BW'(i));

            sdram_guard_bank #(
                .CW(CW), .AW(AW),
                .RCD_GAP(clk_to_gap(RCD_C)), .RAS_GAP(clk_to_gap(RAS_C)),
                .RC_GAP(clk_to_gap(RC_C)),   .RP_GAP(clk_to_gap(RP_C)),
                .WR_GAP(clk_to_gap(WRP_C)),  .RMAX(RMAX_C)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .do_act(do_act[i]), .do_wr(do_wr[i]), .do_pre(do_pre[i]),
                .is_idle(b_idle[i]), .act_ok(b_act_ok[i]), .col_ok(b_col_ok[i]),
                .pre_ok(b_pre_ok[i]), .rp_done(b_rp_done[i]), .overdue(b_overdue[i])
            );
        end
    endgenerate

    sdram_guard_global #(
        .CW(CW),
        .RRD_GAP(clk_to_gap(RRD_C)), .COL_GAP(clk_to_gap(COL_C)),
        .BST_GAP(clk_to_gap(BST_C)), .RFC_GAP(clk_to_gap(RFC_C))
    ) u_global (
        .clk(clk), .rst_n(rst_n),
        .acc_act(accepted && (op == OP_ACT)),
        .acc_wr(accepted && (op == OP_WR)),
        .acc_refresh(accepted && ((op == OP_REF) || (op == OP_SRX))),
        .rrd_ok(rrd_ok), .col_ok(gcol_ok), .bst_ok(bst_ok), .g_ok(g_ok)
    );

    always_comb begin
        rdy                = '0;
        rdy[int'(OP_NOP)]  = 1'b1;
        rdy[int'(OP_ACT)]  = g_ok && b_act_ok[cmd_bank] && rrd_ok;
        rdy[int'(OP_RD)]   = g_ok && b_col_ok[cmd_bank] && gcol_ok;
        rdy[int'(OP_WR)]   = g_ok && b_col_ok[cmd_bank] && gcol_ok;
        rdy[int'(OP_PRE)]  = g_ok && (b_idle[cmd_bank] || b_pre_ok[cmd_bank]);
        rdy[int'(OP_BST)]  = g_ok && bst_ok;
        rdy[int'(OP_REF)]  = g_ok && all_idle && all_rp;
        rdy[int'(OP_SRX)]  = g_ok && all_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            violation <= 1'b0;
        else if (cmd_valid && !rdy[cmd_op])
            violation <= 1'b1;
    end

    assign cmd_ready   = rdy;
    assign row_overdue = |b_overdue;

    // R9: the violation flag never drops without reset
    a_r9_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

endmodule

// File: tb/sdram_cmd_guard_tb.sv
module sdram_cmd_guard_tb;

    localparam int CLK_NS = 10;
    localparam int BL     = 2;
    localparam int RC_NS  = 75;
    localparam int RMX_NS = 200;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    localparam int E_RRD  = cdiv(12, CLK_NS);
    localparam int E_RCD  = cdiv(18, CLK_NS);
    localparam int E_RP   = cdiv(18, CLK_NS);
    localparam int E_RAS  = cdiv(40, CLK_NS);
    localparam int E_RC   = (cdiv(RC_NS, CLK_NS) > E_RAS + E_RP) ? cdiv(RC_NS, CLK_NS) : E_RAS + E_RP;
    localparam int E_RFC  = cdiv(60, CLK_NS);
    localparam int E_RMAX = cdiv(RMX_NS, CLK_NS);
    localparam int E_COL  = BL - 1 + 1;
    localparam int E_BST  = BL - 1 + 1;
    localparam int E_WRP  = BL - 1 + 2;

    localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, BST = 5, REF = 6, SRX = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [1:0] cmd_bank = '0;
    logic [7:0] cmd_ready;
    logic       violation;
    logic       row_overdue;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    sdram_cmd_guard #(
        .CLK_NS(CLK_NS), .BURST_LEN(BL), .T_RC_NS(RC_NS), .T_RAS_MAX_NS(RMX_NS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .violation(violation),
        .row_overdue(row_overdue)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s : got %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input int op, input int bank, input logic v);
        @(negedge clk);
        cmd_op    = 3'(op);
        cmd_bank  = 2'(bank);
        cmd_valid = v;
        #1;
    endtask

    task automatic issue(input int op, input int bank);
        drive(op, bank, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(NOP, 0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // anchor command at cycle 0, then query probe opcode on cycles 1..n+2
    task automatic sweep(input int setup_bank, input int op_a, input int bank_a,
                         input int op_p, input int bank_p, input int n, input string tag);
        do_reset();
        if (setup_bank >= 0) begin
            issue(ACT, setup_bank);
            idle(12);
        end
        issue(op_a, bank_a);
        for (int k = 1; k <= n + 2; k++) begin
            drive(op_p, bank_p, 1'b0);
            check(8'(cmd_ready[op_p]), 8'(k >= n), $sformatf("%s spacing k=%0d", tag, k));
        end
        drive(NOP, 0, 1'b0);
        check(8'(violation), 8'd0, $sformatf("R9 no violation after legal %s", tag));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R2 reset state, all banks
        do_reset();
        for (int b = 0; b < 4; b++) begin
            drive(NOP, b, 1'b0);
            check(cmd_ready, 8'hF3, $sformatf("R2 reset ready bank %0d", b));
        end
        check({6'd0, violation, row_overdue}, 8'd0, "R2 reset flags");

        // R3 RAS-to-CAS for read and write
        sweep(-1, ACT, 0, RD, 0, E_RCD, "R3 act->rd");
        sweep(-1, ACT, 1, WR, 1, E_RCD, "R3 act->wr");
        // R4 RAS minimum
        sweep(-1, ACT, 2, PRE, 2, E_RAS, "R4 act->pre");
        // R5 active-to-active across banks
        sweep(-1, ACT, 0, ACT, 1, E_RRD, "R5 act->act b1");
        sweep(-1, ACT, 3, ACT, 0, E_RRD, "R5 act->act b0");
        // R6 precharge time
        sweep(1, PRE, 1, ACT, 1, E_RP, "R6 pre->act");
        // R7 write recovery
        sweep(0, WR, 0, PRE, 0, E_WRP, "R7 wr->pre");
        sweep(0, WR, 0, RD, 0, E_COL, "R7 wr->rd");
        sweep(0, WR, 0, WR, 0, E_COL, "R7 wr->wr");
        sweep(0, WR, 0, BST, 0, E_BST, "R7 wr->bst");
        sweep(0, RD, 0, RD, 0, 1, "R7 rd->rd");
        // R8 refresh recovery
        sweep(-1, REF, 0, ACT, 2, E_RFC, "R8 ref->act");
        sweep(-1, REF, 0, REF, 0, E_RFC, "R8 ref->ref");
        sweep(-1, SRX, 0, ACT, 1, E_RFC, "R8 srx->act");

        // R1/R6 row cycle: closing early still waits for the row-cycle count
        do_reset();
        issue(ACT, 0);
        for (int k = 1; k < E_RAS; k++) begin
            drive(ACT, 0, 1'b0);
            check(8'(cmd_ready[ACT]), 8'd0, $sformatf("R6 open bank act k=%0d", k));
        end
        issue(PRE, 0);
        for (int k = E_RAS + 1; k <= E_RC + 2; k++) begin
            drive(ACT, 0, 1'b0);
            check(8'(cmd_ready[ACT]), 8'(k >= E_RC), $sformatf("R1 row cycle k=%0d", k));
        end
        check(8'(violation), 8'd0, "R9 no violation row cycle");

        // R4 precharge of idle bank is ready and has no effect
        do_reset();
        drive(PRE, 2, 1'b0);
        check(8'(cmd_ready[PRE]), 8'd1, "R4 idle precharge ready");
        issue(PRE, 2);
        drive(ACT, 2, 1'b0);
        check(8'(cmd_ready[ACT]), 8'd1, "R4 idle precharge no effect");
        check(8'(violation), 8'd0, "R4 idle precharge legal");

        // R8 refresh requires all banks idle and precharged
        do_reset();
        issue(ACT, 2);
        idle(5);
        drive(REF, 0, 1'b0);
        check(8'(cmd_ready[REF]), 8'd0, "R8 ref with open bank");
        issue(PRE, 2);
        for (int k = 1; k <= E_RP + 1; k++) begin
            drive(REF, 1, 1'b0);
            check(8'(cmd_ready[REF]), 8'(k >= E_RP), $sformatf("R8 ref after pre k=%0d", k));
        end

        // R9 blocked command flags and leaves no trace
        do_reset();
        issue(ACT, 0);
        issue(ACT, 1);
        drive(NOP, 0, 1'b0);
        check(8'(violation), 8'd1, "R9 blocked act flagged");
        idle(6);
        drive(ACT, 1, 1'b0);
        check(8'(cmd_ready[ACT]), 8'd1, "R9 blocked act left bank idle");
        drive(RD, 1, 1'b0);
        check(8'(cmd_ready[RD]), 8'd0, "R9 blocked act opened no row");
        drive(RD, 0, 1'b0);
        check(8'(cmd_ready[RD]), 8'd1, "R9 legal act before block kept");
        idle(10);
        check(8'(violation), 8'd1, "R9 violation sticky");

        // R10 overdue row
        do_reset();
        issue(ACT, 3);
        for (int k = 1; k <= E_RMAX + 2; k++) begin
            drive(NOP, 0, 1'b0);
            check(8'(row_overdue), 8'(k >= E_RMAX), $sformatf("R10 overdue k=%0d", k));
        end
        issue(PRE, 3);
        drive(NOP, 0, 1'b0);
        check(8'(row_overdue), 8'd0, "R10 cleared by precharge");
        check(8'(violation), 8'd0, "R10 no violation");

        // R2 reset clears sticky state
        do_reset();
        drive(NOP, 0, 1'b0);
        check({6'd0, violation, row_overdue}, 8'd0, "R2 flags after second reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule